// File: doc/BRIEF.md
# Two-Stage Latch/Register Bus Transceiver

A 10-bit transceiver with three ports. Port A is an input word, port B is an open-drain bus and port C is an output word. Data moves through two capture stages: an A-to-B stage that drives the bus and a B-to-C stage that drives the C outputs. Each stage has its own mode pin and strobe. With the mode pin low the stage is an edge-triggered register. With it high the stage is a latch that is transparent while its strobe is high. All paths are non-inverting.

The design is synchronous to one system clock `clk`. Strobes are sampled on that clock: an edge-triggered capture happens on a clock edge where the strobe is high after being low at the previous edge. A latch stage passes its input through combinationally while its strobe is high, and it records the input on every clock edge during that time. The input of the B-to-C stage is selected by `loop_sel_n`. When it is low the stage takes the A-to-B stage output internally, so a loopback test can run while the bus is released. When it is high the stage takes the bus value `b_in`.

The bus is modelled as open drain. The block only asserts `b_pull` to pull a line low, and it reads the resolved bus on `b_in`. The surrounding logic provides the pull-ups and any other drivers.

Top module: `lbx_transceiver`

## Requirements
- R1: While the synchronous active-high `rst` is high, `b_pull` is 0 and `c_drive` is 0, and both stored words are cleared to 0 on the clock edge. After reset, an edge-triggered stage needs the strobe to be seen low at a clock edge before a rising strobe can capture. A strobe held high across the end of reset does not capture.
- R2: With `ab_mode`=0, the A-to-B stage stores `a_in` on a clock edge where `ab_strobe` is 1 and was 0 at the previous edge. At all other edges it keeps its value, including while the strobe stays high.
- R3: With `ab_mode`=1 and `ab_strobe`=1, the stage output equals `a_in` with no clock delay, and the stage records `a_in` on each clock edge. With `ab_strobe`=0, it holds the value recorded at the last clock edge at which the strobe was high.
- R4: With `b_en_n`=0, `b_pull[i]` equals the inverse of bit i of the A-to-B stage output, so the line is pulled low for a 0 and released for a 1. With `b_en_n`=1, `b_pull` is all zeros.
- R5: With `loop_sel_n`=1, the B-to-C stage takes its input from `b_in`, the resolved bus. If a line is pulled low by this block or by any other driver, it reads as 0 at C (wired-AND).
- R6: With `loop_sel_n`=0, the B-to-C stage takes its input from the A-to-B stage output. This holds whatever the values of `b_en_n` and `b_in`.
- R7: The B-to-C stage follows the same rules as R2 and R3, using `bc_mode` and `bc_strobe`.
- R8: Changing a mode pin while the strobe is low leaves the stored word unchanged. The outputs show the same value in either mode until the next capture.
- R9: With `c_en_n`=0 and reset low, `c_drive` is 1 and `c_out` equals the B-to-C stage output. With `c_en_n`=1, `c_drive` is 0 and `c_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Port A data |
| b_in | input | W | Resolved bus level read back from the B lines |
| b_pull | output | W | Per-line pull-low request onto the B bus |
| c_out | output | W | Port C data, zero while released |
| c_drive | output | 1 | High when the C outputs are driven |
| ab_mode | input | 1 | A-to-B stage mode: 0 register, 1 latch |
| ab_strobe | input | 1 | A-to-B stage clock/latch enable |
| bc_mode | input | 1 | B-to-C stage mode: 0 register, 1 latch |
| bc_strobe | input | 1 | B-to-C stage clock/latch enable |
| loop_sel_n | input | 1 | 0 selects the internal loopback, 1 selects the bus |
| b_en_n | input | 1 | Active-low enable for the bus drivers |
| c_en_n | input | 1 | Active-low enable for the C outputs |

## Verification
The bench holds a register-mode strobe high across the end of reset. A design that captured on the level rather than on a fresh rising edge would load the A word there, and it would also reload the word while the strobe stays high. Latch hold is checked by changing A in the same cycle the strobe falls. A design that stored on the falling edge, or that passed input through while the strobe was low, would show the new word. Loopback is tested with the bus released and forced fully low by another driver, which exposes any leak of `b_in` into the internal path. Switching modes with the strobes low checks that the stored word survives the change, and a wired-AND case checks that another driver pulling a line low is seen on the bus path to C.

// File: rtl/lbx_transceiver.sv
module lbx_transceiver #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_pull,
  output logic [W-1:0] c_out,
  output logic         c_drive,
  input  logic         ab_mode,
  input  logic         ab_strobe,
  input  logic         bc_mode,
  input  logic         bc_strobe,
  input  logic         loop_sel_n,
  input  logic         b_en_n,
  input  logic         c_en_n
);

  logic [W-1:0] ab_q, bc_q, ab_out, bc_in, bc_out;
  logic         ab_prev, bc_prev;
  logic         ab_load, bc_load;

  assign ab_out  = (ab_mode && ab_strobe) ? a_in : ab_q;
  assign bc_in   = loop_sel_n ? b_in : ab_out;
  assign bc_out  = (bc_mode && bc_strobe) ? bc_in : bc_q;

  assign ab_load = ab_mode ? ab_strobe : (ab_strobe && !ab_prev);
  assign bc_load = bc_mode ? bc_strobe : (bc_strobe && !bc_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q    <= '0;
      ab_prev <= 1'b1;
    end else begin
      ab_prev <= ab_strobe;
      if (ab_load) ab_q <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_q    <= '0;
      bc_prev <= 1'b1;
    end else begin
      bc_prev <= bc_strobe;
      if (bc_load) bc_q <= bc_in;
    end
  end

  assign b_pull  = (rst || b_en_n) ? '0 : ~ab_out;
  assign c_drive = !rst && !c_en_n;
  assign c_out   = c_drive ? bc_out : '0;

endmodule

// File: rtl/lbx_transceiver_chk.sv
module lbx_transceiver_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_pull,
  input logic [W-1:0] c_out,
  input logic         c_drive,
  input logic         ab_mode,
  input logic         ab_strobe,
  input logic         bc_mode,
  input logic         bc_strobe,
  input logic         loop_sel_n,
  input logic         b_en_n,
  input logic         c_en_n,
  input logic [W-1:0] ab_q
);

  p_reg_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (!ab_mode && !$rose(ab_strobe)) |=> $stable(ab_q));

  p_reg_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!ab_mode && $rose(ab_strobe) && !$past(rst)) |=> (ab_q == $past(a_in)));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ab_mode && !ab_strobe) |=> $stable(ab_q));

  p_bus_release_r4: assert property (@(posedge clk) disable iff (rst)
    b_en_n |-> (b_pull == '0));

  p_loopback_r6: assert property (@(posedge clk) disable iff (rst)
    (!loop_sel_n && ab_mode && ab_strobe && bc_mode && bc_strobe && !c_en_n)
      |-> (c_out == a_in));

  p_c_release_r9: assert property (@(posedge clk) disable iff (rst)
    c_en_n |-> (!c_drive && c_out == '0));

endmodule

bind lbx_transceiver lbx_transceiver_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_pull(b_pull), .c_out(c_out),
  .c_drive(c_drive), .ab_mode(ab_mode), .ab_strobe(ab_strobe),
  .bc_mode(bc_mode), .bc_strobe(bc_strobe), .loop_sel_n(loop_sel_n),
  .b_en_n(b_en_n), .c_en_n(c_en_n), .ab_q(ab_q)
);

// File: tb/lbx_transceiver_tb.sv
`timescale 1ns/1ps
module lbx_transceiver_tb;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, ext_low, b_in, b_pull, c_out;
  logic c_drive, ab_mode, ab_strobe, bc_mode, bc_strobe, loop_sel_n, b_en_n, c_en_n;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign b_in = ~(b_pull | ext_low);

  lbx_transceiver #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .b_pull(b_pull),
    .c_out(c_out), .c_drive(c_drive), .ab_mode(ab_mode), .ab_strobe(ab_strobe),
    .bc_mode(bc_mode), .bc_strobe(bc_strobe), .loop_sel_n(loop_sel_n),
    .b_en_n(b_en_n), .c_en_n(c_en_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1; a_in = 10'h155; ext_low = '0; ab_mode = 0; ab_strobe = 1;
    bc_mode = 0; bc_strobe = 0; loop_sel_n = 1; b_en_n = 0; c_en_n = 0;
    step(); step();
    chk("R1 bus released in reset", b_pull, '0);
    chk("R1 C released in reset", {9'd0, c_drive}, 10'd0);
    rst = 0;
    step();
    chk("R1 no capture from held strobe", b_pull, 10'h3FF);
    chk("R1 C cleared", c_out, 10'h000);
  endtask

  task automatic t_reg_ab();
    ab_strobe = 0; a_in = 10'h2A5;
    step();
    chk("R2 no capture while low", b_pull, 10'h3FF);
    ab_strobe = 1;
    step();
    chk("R2 capture on rise", b_pull, 10'h15A);
    a_in = 10'h0F0;
    step();
    chk("R2 hold while strobe high", b_pull, 10'h15A);
  endtask

  task automatic t_bus_en();
    b_en_n = 1;
    #1;
    chk("R4 pull off when disabled", b_pull, '0);
    chk("R4 bus floats high", b_in, 10'h3FF);
    b_en_n = 0;
    #1;
  endtask

  task automatic t_latch_ab();
    ab_mode = 1; a_in = 10'h0F0;
    #1;
    chk("R3 transparent", b_pull, 10'h30F);
    step();
    ab_strobe = 0; a_in = 10'h333;
    #1;
    chk("R3 hold after fall", b_pull, 10'h30F);
    step();
    chk("R3 hold next cycle", b_pull, 10'h30F);
  endtask

  task automatic t_bus_path();
    loop_sel_n = 1; bc_mode = 1; bc_strobe = 1; c_en_n = 0;
    #1;
    chk("R5 bus to C", c_out, 10'h0F0);
    ext_low = 10'h010;
    #1;
    chk("R5 wired low", c_out, 10'h0E0);
    ext_low = '0;
    bc_mode = 0; bc_strobe = 0;
    step();
    bc_strobe = 1;
    step();
    chk("R7 BC register capture", c_out, 10'h0F0);
    ext_low = 10'h0F0;
    step();
    chk("R7 BC hold while strobe high", c_out, 10'h0F0);
    ext_low = '0;
  endtask

  task automatic t_loopback();
    loop_sel_n = 0; b_en_n = 1; ab_mode = 1; ab_strobe = 1;
    bc_mode = 1; bc_strobe = 1; a_in = 10'h1C7;
    #1;
    chk("R6 loopback to C", c_out, 10'h1C7);
    chk("R6 bus untouched", b_pull, '0);
    ext_low = 10'h3FF;
    #1;
    chk("R6 immune to bus", c_out, 10'h1C7);
    ext_low = '0;
  endtask

  task automatic t_mode_swap();
    step();
    ab_strobe = 0; bc_strobe = 0;
    step();
    ab_mode = 0; bc_mode = 0; a_in = 10'h000; b_en_n = 0;
    step(); step();
    chk("R8 C kept after swap", c_out, 10'h1C7);
    chk("R8 B kept after swap", b_pull, 10'h238);
    ab_mode = 1; bc_mode = 1;
    step();
    chk("R8 C kept after swap back", c_out, 10'h1C7);
  endtask

  task automatic t_c_en();
    c_en_n = 1;
    #1;
    chk("R9 C released", {9'd0, c_drive}, 10'd0);
    chk("R9 C zero when released", c_out, 10'h000);
    c_en_n = 0;
    #1;
    chk("R9 C driven", c_out, 10'h1C7);
  endtask

  task automatic t_reset_mid();
    rst = 1;
    step();
    rst = 0; ab_mode = 0; bc_mode = 0;
    step();
    chk("R1 C cleared by reset", c_out, 10'h000);
    chk("R1 A stage cleared by reset", b_pull, 10'h3FF);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_reg_ab();
    t_bus_en();
    t_latch_ab();
    t_bus_path();
    t_loopback();
    t_mode_swap();
    t_c_en();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule